// File: doc/BRIEF.md
# Wake-on-LAN Magic Frame Detector

This block sits beside a receive path and inspects one byte of each incoming Ethernet frame per accepted beat while a wake mode is switched on. It looks for a wake pattern that is addressed to this node. The pattern is a run of at least six 0xFF bytes followed at once by sixteen unbroken copies of the node's 48-bit station address. When such a frame ends with a good frame check, a sticky status flag is raised. If interrupts are allowed, a one-cycle wake pulse is raised together with it. While the wake mode is on, the block also tells the receive path to hold back normal frame delivery.

The byte stream arrives on a valid/ready interface with start-of-frame and end-of-frame markers. The CRC result is presented alongside the last byte. The block never applies back-pressure: `rx_ready` is held high, and a beat counts whenever `rx_valid` is high. Idle cycles with `rx_valid` low may fall anywhere inside a frame and have no effect. The station address, the enable, the interrupt enable and the write-one-to-clear strobe are plain control pins.

Top module: `wol_magic_detect`

## Requirements
- R1: `rx_block` equals `wake_en` in the same cycle. `rx_ready` is always 1, so a beat is taken on every cycle with `rx_valid` high.
- R2: Only frames whose destination address (frame bytes 0..5, with byte 0 marked by `rx_sof`) is one of the following can be detected: the station address, the all-ones broadcast address, or any address whose first byte has bit 0 set (group). Frames sent to another single node are never detected.
- R3: Scanning starts at frame byte 12. Bytes 0..11, which hold the destination and source addresses, never count toward the pattern.
- R4: The pattern is six or more consecutive 0xFF bytes, followed directly by 16 copies of the station address. Each copy is compared most significant byte first, starting with `station_addr[47:40]`. The run of 0xFF bytes may begin at any byte position from 12 on.
- R5: If any byte breaks the sixteen-fold run, the search restarts within the same frame. A breaking 0xFF byte counts as the first byte of a new sync run. A 0xFF byte arriving where the first address byte of the first copy is expected extends the sync run and does not break it.
- R6: A match is committed only on the end-of-frame beat with `rx_crc_ok` high. `magic_rcvd` goes high in the cycle after that beat. A bad CRC, or a frame that ends before all 96 address bytes are seen, sets nothing. The last address byte may itself be the end-of-frame beat.
- R7: `wake_pulse` is high for exactly the one cycle in which `magic_rcvd` is set, and only if `wake_irq_en` was high on the committing beat.
- R8: `magic_rcvd` is sticky. A high `stat_clr` clears it in the next cycle. If a set and a clear fall in the same cycle, the flag ends up set.
- R9: While `wake_en` is low, every beat is ignored. Dropping `wake_en` in the middle of a frame abandons that frame, and beats that follow without a new `rx_sof` are ignored.
- R10: After reset, `magic_rcvd` and `wake_pulse` are 0 and the detector is idle.
- R11: A beat with `rx_sof` high discards all state of the previous frame, even if that frame never saw an end-of-frame marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_en | input | 1 | Wake detection mode enable |
| wake_irq_en | input | 1 | Allows the wake pulse |
| stat_clr | input | 1 | Write-one-to-clear strobe for `magic_rcvd` |
| station_addr | input | 48 | Node address; bits 47:40 are sent first |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Always 1; no back-pressure |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | Beat is frame byte 0 |
| rx_eof | input | 1 | Beat is the last byte of the frame |
| rx_crc_ok | input | 1 | Frame check good; read on the end-of-frame beat |
| magic_rcvd | output | 1 | Sticky wake frame received flag |
| wake_pulse | output | 1 | One-cycle wake event |
| rx_block | output | 1 | Suppress normal frame delivery |

## Verification
All internal state is hidden until the end-of-frame beat. A wrong sync count, address byte index, copy count or destination verdict therefore shows at the ports only as `magic_rcvd` and `wake_pulse` being wrong in the cycle after that beat. The error can lie up to a whole frame in the past. The bench makes each frame probe one position: a single corrupted byte at every one of the 96 address positions, sync runs of every length around six, and every kind of destination. Any one miscounted position then turns a single frame's verdict. Status faults, by contrast, show within one cycle of the clear strobe or the committing beat.

// File: rtl/wol_pkg.sv
package wol_pkg;
  // Scanner states: looking for the 0xFF run, matching the address copies,
  // or holding a completed match until the frame restarts.
  typedef enum logic [1:0] {
    SC_SEEK = 2'd0,
    SC_RUN  = 2'd1,
    SC_DONE = 2'd2
  } scan_st_e;

  localparam logic [7:0] SYNC_BYTE = 8'hFF;
endpackage

// File: rtl/wol_dest_filter.sv
module wol_dest_filter #(
  parameter int ADDR_BYTES = 6,
  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1,
  localparam int ADDR_W = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              first,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        rx_byte,
  input  logic [ADDR_W-1:0] station_addr,
  output logic              accept
);
  logic [7:0] addr_b [ADDR_BYTES];
  logic       own_q;
  logic       group_q;
  logic       byte_eq;

  // The first byte on the wire is the most significant address byte.
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    assign addr_b[g] = station_addr[(ADDR_BYTES-1-g)*8 +: 8];
  end

  assign byte_eq = (rx_byte == addr_b[idx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q   <= 1'b0;
      group_q <= 1'b0;
    end else if (take) begin
      if (first) begin
        own_q   <= byte_eq;
        group_q <= rx_byte[0];
      end else begin
        own_q   <= own_q & byte_eq;
      end
    end
  end

  // Broadcast has the group bit set, so it is covered by group_q.
  assign accept = own_q | group_q;
endmodule

// File: rtl/wol_pattern_scan.sv
module wol_pattern_scan
  import wol_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int SYNC_LEN   = 6,
  parameter int REPEATS    = 16,
  localparam int IDX_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1,
  localparam int REP_W  = (REPEATS > 1) ? $clog2(REPEATS) : 1,
  localparam int FF_W   = $clog2(SYNC_LEN + 1),
  localparam int ADDR_W = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step,
  input  logic [7:0]        rx_byte,
  input  logic [ADDR_W-1:0] station_addr,
  output logic              hit
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ADDR_BYTES - 1);
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPEATS - 1);
  localparam logic [FF_W-1:0]  FF_LAST  = FF_W'(SYNC_LEN - 1);

  logic [7:0]       addr_b [ADDR_BYTES];
  scan_st_e         st_q, st_d;
  logic [FF_W-1:0]  ff_q, ff_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             is_sync, is_exp, at_first;

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    assign addr_b[g] = station_addr[(ADDR_BYTES-1-g)*8 +: 8];
  end

  assign is_sync  = (rx_byte == SYNC_BYTE);
  assign is_exp   = (rx_byte == addr_b[idx_q]);
  assign at_first = (idx_q == '0) && (rep_q == '0);

  always_comb begin
    st_d  = st_q;
    ff_d  = ff_q;
    idx_d = idx_q;
    rep_d = rep_q;
    if (restart) begin
      st_d  = SC_SEEK;
      ff_d  = '0;
      idx_d = '0;
      rep_d = '0;
    end else if (step) begin
      unique case (st_q)
        SC_SEEK: begin
          if (!is_sync) begin
            ff_d = '0;
          end else if (ff_q == FF_LAST) begin
            st_d  = SC_RUN;
            ff_d  = '0;
            idx_d = '0;
            rep_d = '0;
          end else begin
            ff_d = ff_q + 1'b1;
          end
        end
        SC_RUN: begin
          if (is_exp) begin
            if (idx_q == IDX_LAST) begin
              idx_d = '0;
              if (rep_q == REP_LAST) st_d = SC_DONE;
              else                   rep_d = rep_q + 1'b1;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else if (is_sync && at_first) begin
            st_d = SC_RUN;                // longer sync run, stay armed
          end else begin
            st_d  = SC_SEEK;
            idx_d = '0;
            rep_d = '0;
            ff_d  = is_sync ? FF_W'(1) : '0;
          end
        end
        SC_DONE: st_d = SC_DONE;
        default: st_d = SC_SEEK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SC_SEEK;
      ff_q  <= '0;
      idx_q <= '0;
      rep_q <= '0;
    end else begin
      st_q  <= st_d;
      ff_q  <= ff_d;
      idx_q <= idx_d;
      rep_q <= rep_d;
    end
  end

  // Includes a match completed by the current byte.
  assign hit = (st_d == SC_DONE);
endmodule

// File: rtl/wol_status.sv
module wol_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      if (set)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      pulse <= set & irq_en;
    end
  end
endmodule

// File: rtl/wol_magic_detect.sv
module wol_magic_detect #(
  parameter int ADDR_BYTES = 6,
  parameter int SYNC_LEN   = 6,
  parameter int REPEATS    = 16,
  localparam int ADDR_W  = 8 * ADDR_BYTES,
  localparam int HDR_LEN = 2 * ADDR_BYTES,
  localparam int POS_W   = $clog2(HDR_LEN + 1),
  localparam int IDX_W   = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_en,
  input  logic              wake_irq_en,
  input  logic              stat_clr,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_crc_ok,
  output logic              magic_rcvd,
  output logic              wake_pulse,
  output logic              rx_block
);
  localparam logic [POS_W-1:0] HDR_END = POS_W'(HDR_LEN);
  localparam logic [POS_W-1:0] DA_END  = POS_W'(ADDR_BYTES);

  logic             beat, sof_beat, frame_beat;
  logic             in_frame_q;
  logic [POS_W-1:0] pos_q, cur_pos;
  logic             da_take, da_accept;
  logic             scan_step, scan_restart, scan_hit;
  logic             commit;

  assign rx_ready   = 1'b1;
  assign rx_block   = wake_en;

  assign beat       = rx_valid & wake_en;
  assign sof_beat   = beat & rx_sof;
  assign frame_beat = beat & (rx_sof | in_frame_q);
  assign cur_pos    = rx_sof ? '0 : pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      pos_q      <= '0;
    end else begin
      if (!wake_en)                  in_frame_q <= 1'b0;
      else if (frame_beat && rx_eof) in_frame_q <= 1'b0;
      else if (sof_beat)             in_frame_q <= 1'b1;

      if (sof_beat)                             pos_q <= POS_W'(1);
      else if (frame_beat && pos_q < HDR_END)   pos_q <= pos_q + 1'b1;
    end
  end

  assign da_take      = frame_beat & (cur_pos < DA_END);
  assign scan_restart = sof_beat | ~wake_en;
  assign scan_step    = frame_beat & ~rx_sof & (pos_q >= HDR_END);

  wol_dest_filter #(.ADDR_BYTES(ADDR_BYTES)) i_filter (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (da_take),
    .first        (rx_sof),
    .idx          (cur_pos[IDX_W-1:0]),
    .rx_byte      (rx_data),
    .station_addr (station_addr),
    .accept       (da_accept)
  );

  wol_pattern_scan #(
    .ADDR_BYTES (ADDR_BYTES),
    .SYNC_LEN   (SYNC_LEN),
    .REPEATS    (REPEATS)
  ) i_scan (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (scan_restart),
    .step         (scan_step),
    .rx_byte      (rx_data),
    .station_addr (station_addr),
    .hit          (scan_hit)
  );

  assign commit = frame_beat & rx_eof & rx_crc_ok & da_accept & scan_hit;

  wol_status i_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (commit),
    .clr    (stat_clr),
    .irq_en (wake_irq_en),
    .flag   (magic_rcvd),
    .pulse  (wake_pulse)
  );
endmodule

// File: rtl/wol_magic_detect_chk.sv
module wol_magic_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic wake_en,
  input logic wake_irq_en,
  input logic stat_clr,
  input logic rx_valid,
  input logic rx_eof,
  input logic rx_crc_ok,
  input logic magic_rcvd,
  input logic wake_pulse
);
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    magic_rcvd && !stat_clr |=> magic_rcvd);                                   // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr && !(rx_valid && rx_eof) |=> !magic_rcvd);                        // R8
  AST_SET_ON_GOOD_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(magic_rcvd) |-> $past(rx_valid && rx_eof && rx_crc_ok));             // R6
  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(magic_rcvd) |-> $past(wake_en));                                     // R9
  AST_PULSE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> magic_rcvd && $past(wake_irq_en));                          // R7
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);                                               // R7
  AST_PULSE_NEEDS_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(rx_valid && rx_eof && rx_crc_ok));                    // R6
endmodule

bind wol_magic_detect wol_magic_detect_chk i_chk (.*);

// File: tb/test_wol_magic_detect.sv
module test_wol_magic_detect;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] STA = 48'h0A1B2C3D4E5F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake_en = 1'b0, wake_irq_en = 1'b0, stat_clr = 1'b0;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_crc_ok = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_ready, magic_rcvd, wake_pulse, rx_block;

  int checks = 0, errors = 0;
  logic [7:0] fb [0:511];
  int flen = 0;
  bit gap_mode = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wol_magic_detect i_wol_magic_detect (
    .clk(clk), .rst_n(rst_n), .wake_en(wake_en), .wake_irq_en(wake_irq_en),
    .stat_clr(stat_clr), .station_addr(STA), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_crc_ok(rx_crc_ok), .magic_rcvd(magic_rcvd), .wake_pulse(wake_pulse),
    .rx_block(rx_block)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ab(input int i);
    return 8'(STA >> (8 * (5 - i)));
  endfunction

  task automatic fput(input logic [7:0] b); fb[flen] = b; flen++; endtask
  task automatic fff(input int n); for (int i = 0; i < n; i++) fput(8'hFF); endtask
  task automatic fcopies(input int n);
    for (int k = 0; k < 6 * n; k++) fput(ab(k % 6));
  endtask
  // kind 0 own, 1 broadcast, 2 multicast, 3 other unicast
  task automatic fhdr(input int kind);
    flen = 0;
    for (int i = 0; i < 6; i++) begin
      case (kind)
        0: fput(ab(i));
        1: fput(8'hFF);
        2: fput(i == 0 ? 8'h01 : 8'(i));
        default: fput(i == 0 ? 8'h02 : 8'(i + 16));
      endcase
    end
    for (int i = 0; i < 6; i++) fput(8'hA0 + 8'(i));
  endtask

  task automatic send(input bit crc, input bit clr_eof, input bit no_eof, input int drop_at);
    for (int i = 0; i < flen; i++) begin
      if (i == drop_at) begin
        @(negedge clk); rx_valid = 1'b0; wake_en = 1'b0;
        @(negedge clk); wake_en = 1'b1;
      end
      @(negedge clk);
      rx_valid  = 1'b1;
      rx_data   = fb[i];
      rx_sof    = (i == 0);
      rx_eof    = (i == flen - 1) && !no_eof;
      rx_crc_ok = rx_eof && crc;
      stat_clr  = rx_eof && clr_eof;
      if (gap_mode && (i % 5 == 4) && (i != flen - 1)) begin
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_crc_ok = 1'b0;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_crc_ok = 1'b0; stat_clr = 1'b0;
  endtask

  task automatic clear_status();
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
  endtask

  task automatic expect_frame(input string req, input bit crc, input bit exp);
    clear_status();
    send(crc, 1'b0, 1'b0, -1);
    chk(req, 32'(magic_rcvd), 32'(exp));
    chk(req, 32'(wake_pulse), 32'(exp && wake_irq_en));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 flag", 32'(magic_rcvd), 0);
    chk("R10 pulse", 32'(wake_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 flag after release", 32'(magic_rcvd), 0);
    chk("R1 block off", 32'(rx_block), 0);
    chk("R1 ready", 32'(rx_ready), 1);
    wake_en = 1'b1; wake_irq_en = 1'b1;
    #1;
    chk("R1 block on", 32'(rx_block), 1);

    // R2 destination kinds, with and without idle gaps
    for (int g = 0; g < 2; g++) begin
      gap_mode = (g == 1);
      for (int kind = 0; kind < 4; kind++) begin
        fhdr(kind); fff(6); fcopies(16);
        expect_frame("R2 destination", 1'b1, kind != 3);
      end
    end
    gap_mode = 1'b0;

    // R3 sync inside header does not count; R4 any offset and sync lengths
    fhdr(1); for (int i = 6; i < 12; i++) fb[i] = 8'hFF; fcopies(16);
    expect_frame("R3 header sync", 1'b1, 1'b0);
    fhdr(1); for (int i = 6; i < 12; i++) fb[i] = 8'hFF; fff(6); fcopies(16);
    expect_frame("R3 sync after header", 1'b1, 1'b1);
    for (int gap = 0; gap < 4; gap++)
      for (int n = 1; n <= 9; n++) begin
        fhdr(0); for (int j = 0; j < 3 * gap; j++) fput(8'h33); fff(n); fcopies(16);
        expect_frame("R4 sync length", 1'b1, n >= 6);
      end
    fhdr(0); fff(6); fcopies(15);
    expect_frame("R4 fifteen copies", 1'b1, 1'b0);

    // R5 break at every address byte position, then retry
    for (int p = 0; p < 96; p++) begin
      fhdr(0); fff(6);
      for (int k = 0; k < 96; k++) fput(k == p ? (ab(k % 6) ^ 8'h01) : ab(k % 6));
      expect_frame("R5 break", 1'b1, 1'b0);
      fff(6); fcopies(16);
      expect_frame("R5 break then retry", 1'b1, 1'b1);
    end
    // R5 breaking 0xFF starts a new sync run
    for (int n = 1; n <= 8; n++) begin
      fhdr(0); fff(6); fcopies(3); fff(n); fcopies(16);
      expect_frame("R5 break on FF", 1'b1, n >= 6);
    end

    // R6 bad CRC, short frame, match on the last beat
    fhdr(0); fff(6); fcopies(16);
    expect_frame("R6 bad crc", 1'b0, 1'b0);
    fhdr(0); fff(6); fcopies(16); flen = flen - 1;
    expect_frame("R6 short frame", 1'b1, 1'b0);
    fhdr(0); fff(6); fcopies(16); fput(8'h55); fput(8'h66);
    expect_frame("R6 trailing bytes", 1'b1, 1'b1);

    // R7 pulse gated by interrupt enable
    wake_irq_en = 1'b0;
    fhdr(0); fff(6); fcopies(16);
    expect_frame("R7 irq off", 1'b1, 1'b1);
    wake_irq_en = 1'b1;
    @(negedge clk);
    chk("R7 pulse one cycle", 32'(wake_pulse), 0);

    // R8 sticky, clear, set wins over clear
    fhdr(3); fff(6); fcopies(16);
    send(1'b1, 1'b0, 1'b0, -1);
    chk("R8 sticky", 32'(magic_rcvd), 1);
    clear_status();
    chk("R8 cleared", 32'(magic_rcvd), 0);
    fhdr(0); fff(6); fcopies(16);
    send(1'b1, 1'b1, 1'b0, -1);
    chk("R8 set wins", 32'(magic_rcvd), 1);

    // R9 disabled and mid-frame disable
    wake_en = 1'b0;
    fhdr(0); fff(6); fcopies(16);
    expect_frame("R9 disabled", 1'b1, 1'b0);
    chk("R1 block follows", 32'(rx_block), 0);
    wake_en = 1'b1;
    fhdr(0); fff(6); fcopies(16);
    clear_status();
    send(1'b1, 1'b0, 1'b0, 40);
    chk("R9 mid-frame disable", 32'(magic_rcvd), 0);

    // R11 restart at start of frame
    fhdr(0); fff(6); fcopies(10);
    clear_status();
    send(1'b1, 1'b0, 1'b1, -1);
    fhdr(0); fcopies(6);
    expect_frame("R11 restart partial", 1'b1, 1'b0);
    fhdr(0); fff(6); fcopies(10);
    send(1'b1, 1'b0, 1'b1, -1);
    fhdr(2); fff(7); fcopies(16);
    expect_frame("R11 restart full", 1'b1, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule